// File: doc/BRIEF.md
# Erased Sector Zero-Bit Judge

When a NAND sector read back through a BCH decoder is reported as having more errors than the code can fix, the cause is often not damage. The sector may simply have been erased. An erased page reads as all ones in both data and stored parity, but all-ones parity is not the parity of all-ones data, so the decoder reports a failure. This block streams the sector past a pair of zero-bit counters to tell the two cases apart.

The controller pulses `start` together with the decoder's error count. If that count is above the correction limit, the block arms. It then accepts the 512 data bytes followed by the 13 stored parity bytes, one byte per cycle, with a valid strobe and a last strobe. It counts zero bits separately in the data region and the parity region, and each count saturates just past the limit.

One cycle after the last byte, the block pulses `done` and presents a verdict, which holds until the next `start`. The verdict is one of three: an erased sector with clean data, an erased sector whose data must be forced to all ones, or an uncorrectable sector. It also reports the number of data bits that the forcing repairs.

Top module: `erased_sector_judge`

## Requirements
- R1: After reset, `verdict` is 2'b00 (none), `done` is 0, `force_ones` is 0 and `fix_count` is 0.
- R2: A `start` whose `dec_errs` is 8 or less leaves the block idle. Bytes that follow are ignored, no `done` pulse appears, and `verdict` stays 2'b00.
- R3: A `start` whose `dec_errs` exceeds 8 arms the block. The first 512 accepted bytes count as data and the accepted bytes after them count as stored parity.
- R4: Each accepted byte adds its number of zero bits to the count of its region. Each count saturates at 9, so any larger number of zeros in one region (for example 17) still reads as 9 and never wraps.
- R5: If data zeros plus parity zeros total 8 or fewer and the data zero count is 0, the verdict is 2'b01 (erased, clean), `force_ones` is 0 and `fix_count` is 0.
- R6: If the total is 8 or fewer and the data zero count is nonzero, the verdict is 2'b10 (erased, fix), `force_ones` is 1 and `fix_count` equals the data zero count.
- R7: If the total exceeds 8, the verdict is 2'b11 (uncorrectable), `force_ones` is 0 and `fix_count` is 0.
- R8: `done` is high for exactly one cycle, namely the cycle after the byte with `in_last` is accepted. The verdict outputs are valid from that cycle.
- R9: The verdict outputs hold until the next `start`. A `start` clears both counters and returns the verdict outputs to their reset values.
- R10: A cycle with `in_valid` low adds nothing to either count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new sector; samples `dec_errs` |
| dec_errs | input | 5 | Error count reported by the decoder for this sector |
| in_valid | input | 1 | `in_byte` carries a sector byte this cycle |
| in_byte | input | 8 | Sector byte, data first, then stored parity |
| in_last | input | 1 | Marks the final byte of the sector |
| done | output | 1 | One-cycle pulse when the verdict becomes valid |
| verdict | output | 2 | 00 none, 01 erased clean, 10 erased fix, 11 uncorrectable |
| force_ones | output | 1 | Data region must be rewritten as all ones |
| fix_count | output | 4 | Number of data bits repaired by forcing |

## Verification
A counter that wraps or misses saturation shows up as an erased verdict for a sector that holds many zeros. A region boundary placed wrongly moves zeros between `fix_count` and the parity total. Both errors are visible at the single `done` cycle of the affected sector. A stale arm state or a cleared hold shows up as an unexpected `done`, or as a verdict that changes between sectors, within the next few cycles. The bench therefore compares each verdict at `done`, rechecks it after idle cycles, and streams decoy bytes while the block is unarmed or while `in_valid` is low.

// File: rtl/erased_sector_judge.sv
module erased_sector_judge #(
  parameter int DATA_BYTES = 512,
  parameter int ECC_BYTES  = 13,
  parameter int LIMIT      = 8,
  parameter int ERR_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ERR_W-1:0] dec_errs,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  output logic             done,
  output logic [1:0]       verdict,
  output logic             force_ones,
  output logic [3:0]       fix_count
);
  localparam int CNT_W = $clog2(LIMIT + 2);
  localparam int IDX_W = $clog2(DATA_BYTES + ECC_BYTES + 1);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DATA_BYTES + ECC_BYTES);
  localparam logic [1:0] V_NONE = 2'b00, V_CLEAN = 2'b01, V_FIX = 2'b10, V_BAD = 2'b11;

  logic             armed;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] dz, ez, dz_nxt, ez_nxt;
  logic [CNT_W:0]   total;
  logic [3:0]       bz;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [3:0] b);
    logic [CNT_W+3:0] s;
    s = (CNT_W+4)'(a) + (CNT_W+4)'(b);
    return (s > (CNT_W+4)'(SAT)) ? SAT : s[CNT_W-1:0];
  endfunction

  wire take    = armed & in_valid;
  wire finish  = take & in_last;
  wire in_data = idx < IDX_W'(DATA_BYTES);

  assign bz     = 4'($countones(~in_byte));
  assign dz_nxt = (take && in_data)  ? sat_add(dz, bz) : dz;
  assign ez_nxt = (take && !in_data) ? sat_add(ez, bz) : ez;
  assign total  = (CNT_W+1)'(dz_nxt) + (CNT_W+1)'(ez_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0; idx <= '0; dz <= '0; ez <= '0;
      done <= 1'b0; verdict <= V_NONE; force_ones <= 1'b0; fix_count <= '0;
    end else if (start) begin
      armed <= dec_errs > ERR_W'(LIMIT);
      idx <= '0; dz <= '0; ez <= '0;
      done <= 1'b0; verdict <= V_NONE; force_ones <= 1'b0; fix_count <= '0;
    end else begin
      done <= finish;
      if (take) begin
        dz <= dz_nxt;
        ez <= ez_nxt;
        if (idx != IDX_MAX) idx <= idx + 1'b1;
      end
      if (finish) begin
        armed <= 1'b0;
        if (total <= (CNT_W+1)'(LIMIT)) begin
          verdict    <= (dz_nxt == '0) ? V_CLEAN : V_FIX;
          force_ones <= dz_nxt != '0;
          fix_count  <= 4'(dz_nxt);
        end else begin
          verdict    <= V_BAD;
          force_ones <= 1'b0;
          fix_count  <= '0;
        end
      end
    end
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n) dz <= SAT && ez <= SAT); // R4
  AST_FORCE_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    force_ones |-> (verdict == V_FIX && fix_count != 0 && fix_count <= 4'(LIMIT))); // R6
  AST_BAD_NOFIX: assert property (@(posedge clk) disable iff (!rst_n)
    verdict == V_BAD |-> (!force_ones && fix_count == 0)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !finish) |=> $stable(verdict) && $stable(fix_count)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !start) |=> !done); // R2
endmodule

// File: tb/erased_sector_judge_tb.sv
module erased_sector_judge_tb;
  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, in_last = 0;
  logic [4:0] dec_errs = 0;
  logic [7:0] in_byte = 8'h00;
  logic done, force_ones;
  logic [1:0] verdict;
  logic [3:0] fix_count;
  int checks = 0, errors = 0;
  logic [6:0] expq[$];
  logic [6:0] last_exp = 7'd0;

  always #2 clk = ~clk;

  erased_sector_judge u_dut (.clk(clk), .rst_n(rst_n), .start(start), .dec_errs(dec_errs),
    .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last), .done(done),
    .verdict(verdict), .force_ones(force_ones), .fix_count(fix_count));

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare each done against scoreboard (R5 R6 R7 R8)
  always @(negedge clk) if (rst_n && done) begin
    if (expq.size() == 0) check("R2_unexpected_done", 7'h7F, 7'h00);
    else begin
      last_exp = expq.pop_front();
      check("R5_R6_R7_verdict", {verdict, force_ones, fix_count}, last_exp);
    end
  end

  function automatic logic [7:0] zbyte(input int pos, input int n, input bit packed_z);
    int z;
    if (n <= 0 || pos < 0) return 8'hFF;
    if (packed_z) begin
      z = n - 8 * pos;
      if (z <= 0) return 8'hFF;
      if (z > 8) z = 8;
      return 8'hFF << z;
    end
    return (pos < n) ? 8'hBF : 8'hFF;
  endfunction

  task automatic sector(input int errs, input int nd, input int ne, input bit packed_z, input bit gaps);
    int dze, eze, tot;
    logic [6:0] e;
    @(posedge clk); #1; start = 1; dec_errs = 5'(errs);
    @(posedge clk); #1; start = 0;
    dze = nd > 9 ? 9 : nd; eze = ne > 9 ? 9 : ne; tot = dze + eze;
    if (tot > 8) e = {2'b11, 1'b0, 4'd0};
    else if (dze == 0) e = {2'b01, 1'b0, 4'd0};
    else e = {2'b10, 1'b1, 4'(dze)};
    if (errs > 8) expq.push_back(e);
    for (int i = 0; i < 525; i++) begin
      if (gaps && (i % 37 == 5)) begin
        in_valid = 0; in_byte = 8'h00; in_last = 1; // R10 decoy
        @(posedge clk); #1;
      end
      in_valid = 1; in_last = (i == 524);
      in_byte = (i < 512) ? zbyte(i - 100, nd, packed_z) : zbyte(i - 512, ne, packed_z);
      @(posedge clk); #1;
    end
    in_valid = 0; in_last = 0; in_byte = 8'h00;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    fork
      begin repeat (100000) @(posedge clk); check("watchdog", 7'h01, 7'h00); end
      begin
        repeat (3) @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        check("R1_reset", {done, verdict, force_ones, fix_count}, 7'd0);
        sector(12, 0, 0, 1, 0);  // R5 clean
        sector(9, 3, 0, 0, 0);   // R6 fix count 3
        sector(20, 0, 8, 1, 0);  // R5 parity zeros only, total 8
        sector(15, 5, 3, 0, 1);  // R6 total 8 with gaps R10
        sector(10, 8, 0, 1, 0);  // R6 packed full byte
        sector(9, 5, 4, 0, 0);   // R7 total 9
        sector(9, 17, 0, 1, 0);  // R4 saturation, no wrap -> R7
        sector(31, 0, 13, 1, 0); // R7 parity region R3
        sector(11, 1, 0, 0, 1);  // R6 one bit, gaps R10
        @(negedge clk);
        check("R9_hold", {verdict, force_ones, fix_count}, last_exp);
        sector(8, 40, 40, 1, 0); // R2 ignored
        @(negedge clk);
        check("R2_idle_verdict", {verdict, force_ones, fix_count}, 7'd0);
        check("R9_start_clears", {done, verdict}, 3'd0);
        sector(3, 0, 0, 1, 0);
        @(negedge clk);
        check("R8_queue_empty", 7'(expq.size()), 7'd0);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule